// File: doc/BRIEF.md
# IO Page Access Decoder

This block stands between a CPU bus with 24 decoded address bits and the peripheral register slots of the top IO page (0xFF8000 to 0xFFFFFF). For every accepted byte, word or long access it looks at each byte lane on its own. A lane is a mapped register, a void location, or a hole. A void location reads a fixed 0xFF or 0x00 and ignores writes. A hole is a location that would fault. The block raises a bus error only when every lane of the access is a hole. A wide access that reaches at least one valid byte therefore completes, and its hole lanes read back 0xFF.

Before a lane is classified, addresses in the sound-chip shadow window are folded onto the base registers. Mapped lanes raise a per-lane select and a per-register strobe in the cycle the request is accepted. The peripherals answer on a lane-indexed read bus in that same cycle. The response returns one cycle later, carrying the right-justified read data, the bus error flag and an illegal flag for accesses that would run past the end of the address space. Requests and responses use valid/ready. A request is taken only while the single response register is empty or is being drained in that cycle. A response that is held back keeps all of its fields stable.

Top module: `io_space_decoder`

## Requirements
- R1: Only address bits 23:0 are decoded. Bits 31:24 of `req_addr` have no effect on any output.
- R2: An access whose base address is below 0xFF8000, or any access with `req_super` low, returns `rsp_berr`=1 with `rsp_illegal`=0 and zero read data. It raises no lane select and no strobe.
- R3: `req_size` encodes 00=byte, 01=word (2 bytes), 10=long (4 bytes); 11 is illegal. Code 11, a word above 0xFFFFFE or a long above 0xFFFFFC returns `rsp_illegal`=1 with `rsp_berr`=0 and zero data, and raises no select. A word at 0xFFFFFE and a long at 0xFFFFFC are legal.
- R4: A legal supervisor access in the region returns `rsp_berr`=1 exactly when the number of hole lanes equals the access width. Otherwise it completes with `rsp_berr`=0.
- R5: Read data for a completed read is big-endian and right-justified: the lowest address is the most significant byte of the access. A mapped lane k takes `periph_rdata[31-8k:24-8k]`. Hole lanes and void-FF lanes read 0xFF, and void-00 lanes read 0x00. `rsp_rdata` is zero for writes and for any errored or illegal access.
- R6: Only mapped lanes of an accepted legal access raise `lane_sel[k]`. Writes to void or hole lanes raise nothing. `slot_write` is high with any select of a write. `bus_wdata` places the write data lane-indexed, with lane k at bits [31-8k:24-8k].
- R7: A lane address from 0xFF8804 to 0xFF88FF is folded by AND with 0xFFF803 before classification. `lane_addr` lane k (bits [24k+23:24k]) shows the folded address.
- R8: `slot_strobe[s]` rises once for every distinct mapped register an access touches, however many of its lanes are covered. Lanes do not raise it once each.
- R9: `req_ready` = !`rsp_valid` | `rsp_ready`. The response appears the cycle after acceptance. While `rsp_valid` is high and `rsp_ready` is low, the response fields stay stable and no request is taken.
- R10: After reset `rsp_valid` is low and `req_ready` is high.
- R11: The register map is as follows. Slot 0 is the byte at 0xFF8001. Slot 1 is the word at 0xFF8200-0xFF8201. Slot 2 is the byte at 0xFF8800 and slot 3 is the byte at 0xFF8802. Slot 4 is the long at 0xFFFA00-0xFFFA03. Void-FF covers 0xFF8204-0xFF8207 and void-00 covers 0xFF8208-0xFF8209. Every other address is a hole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 32 | CPU byte address (low 24 bits decoded) |
| req_size | input | 2 | Access size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_super | input | 1 | CPU in supervisor mode |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Read data, right-justified |
| rsp_berr | output | 1 | Bus error for this access |
| rsp_illegal | output | 1 | Access runs past the address space or has a bad size |
| slot_strobe | output | 5 | One strobe per register touched |
| slot_write | output | 1 | Selects belong to a write |
| lane_sel | output | 4 | Per-lane mapped register select |
| lane_addr | output | 96 | Folded address of each lane |
| bus_wdata | output | 32 | Lane-indexed write data |
| periph_rdata | input | 32 | Lane-indexed read data from peripherals |

## Verification
The bench attacks the aggregation rule with word and long accesses that straddle a hole and a mapped or void byte. A design that faults per lane would raise a bus error there, and one that faults on any hole would never complete them. Shadow addresses at both ends of the fold window, plus a long access spanning two byte registers, expose a missing fold or a strobe raised once per lane. The address-space end (0xFFFFFC/0xFFFFFE against one byte further) and size code 11 catch off-by-one limits. A response held under back-pressure catches a response register that is overwritten early.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;

  localparam int ADDR_W = 24;
  localparam int LANES  = 4;
  localparam int DATA_W = 8 * LANES;
  localparam int CNT_W  = $clog2(LANES + 1);
  localparam int NSLOT  = 5;
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int NROWS  = 7;

  localparam logic [ADDR_W-1:0] REGION_BASE = 24'hFF8000;
  localparam logic [ADDR_W-1:0] SHADOW_LO   = 24'hFF8804;
  localparam logic [ADDR_W-1:0] SHADOW_HI   = 24'hFF88FF;
  localparam logic [ADDR_W-1:0] SHADOW_MASK = 24'hFFF803;

  typedef enum logic [1:0] {
    LK_HOLE    = 2'd0,
    LK_REG     = 2'd1,
    LK_VOID_FF = 2'd2,
    LK_VOID_00 = 2'd3
  } lane_kind_e;

  typedef struct packed {
    logic [ADDR_W-1:0] lo;
    logic [ADDR_W-1:0] hi;
    lane_kind_e        kind;
    logic [SLOT_W-1:0] slot;
  } map_row_t;

  // Range table; a lower row index wins on overlap.
  function automatic map_row_t map_row(input int idx);
    map_row_t r;
    case (idx)
      0:       r = '{lo: 24'hFF8001, hi: 24'hFF8001, kind: LK_REG,     slot: SLOT_W'(0)};
      1:       r = '{lo: 24'hFF8200, hi: 24'hFF8201, kind: LK_REG,     slot: SLOT_W'(1)};
      2:       r = '{lo: 24'hFF8800, hi: 24'hFF8800, kind: LK_REG,     slot: SLOT_W'(2)};
      3:       r = '{lo: 24'hFF8802, hi: 24'hFF8802, kind: LK_REG,     slot: SLOT_W'(3)};
      4:       r = '{lo: 24'hFFFA00, hi: 24'hFFFA03, kind: LK_REG,     slot: SLOT_W'(4)};
      5:       r = '{lo: 24'hFF8204, hi: 24'hFF8207, kind: LK_VOID_FF, slot: SLOT_W'(0)};
      6:       r = '{lo: 24'hFF8208, hi: 24'hFF8209, kind: LK_VOID_00, slot: SLOT_W'(0)};
      default: r = '{lo: '1,         hi: '0,         kind: LK_HOLE,    slot: SLOT_W'(0)};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/io_lane_classify.sv
module io_lane_classify
  import io_dec_pkg::*;
#(
  parameter bit SHADOW_EN = 1'b1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] folded_o,
  output lane_kind_e        kind_o,
  output logic [SLOT_W-1:0] slot_o
);

  map_row_t row;

  always_comb begin
    folded_o = addr_i;
    if (SHADOW_EN && (addr_i >= SHADOW_LO) && (addr_i <= SHADOW_HI))
      folded_o = addr_i & SHADOW_MASK;

    kind_o = LK_HOLE;
    slot_o = '0;
    row    = map_row(NROWS);
    // walk from the last row down so the first row has final say
    for (int r = NROWS - 1; r >= 0; r--) begin
      row = map_row(r);
      if ((folded_o >= row.lo) && (folded_o <= row.hi)) begin
        kind_o = row.kind;
        slot_o = row.slot;
      end
    end
  end

endmodule

// File: rtl/io_select_gen.sv
module io_select_gen
  import io_dec_pkg::*;
(
  input  logic                         go_i,
  input  logic [LANES-1:0]             act_i,
  input  lane_kind_e [LANES-1:0]       kind_i,
  input  logic [LANES-1:0][SLOT_W-1:0] slot_i,
  input  logic [CNT_W-1:0]             width_i,
  output logic [LANES-1:0]             lane_sel_o,
  output logic [NSLOT-1:0]             slot_strobe_o,
  output logic                         all_hole_o
);

  logic [CNT_W-1:0] hole_cnt;

  always_comb begin
    lane_sel_o    = '0;
    slot_strobe_o = '0;
    hole_cnt      = '0;
    for (int k = 0; k < LANES; k++) begin
      if (act_i[k] && (kind_i[k] == LK_HOLE))
        hole_cnt = hole_cnt + CNT_W'(1);
      if (go_i && act_i[k] && (kind_i[k] == LK_REG)) begin
        lane_sel_o[k] = 1'b1;
        // lanes of one register merge into a single strobe bit
        for (int s = 0; s < NSLOT; s++)
          if (slot_i[k] == SLOT_W'(s))
            slot_strobe_o[s] = 1'b1;
      end
    end
  end

  assign all_hole_o = (hole_cnt == width_i);

endmodule

// File: rtl/io_read_fill.sv
module io_read_fill
  import io_dec_pkg::*;
(
  input  logic [LANES-1:0]       act_i,
  input  lane_kind_e [LANES-1:0] kind_i,
  input  logic [DATA_W-1:0]      periph_i,
  input  logic [CNT_W-1:0]       width_i,
  output logic [DATA_W-1:0]      rdata_o
);

  logic [DATA_W-1:0] lanes_w;

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      logic [7:0] b;
      if (!act_i[k])                  b = 8'h00;
      else if (kind_i[k] == LK_REG)     b = periph_i[8*(LANES-1-k) +: 8];
      else if (kind_i[k] == LK_VOID_00) b = 8'h00;
      else                              b = 8'hFF;
      lanes_w[8*(LANES-1-k) +: 8] = b;
    end
    rdata_o = lanes_w >> (8 * (LANES - int'(width_i)));
  end

endmodule

// File: rtl/io_space_decoder.sv
module io_space_decoder
  import io_dec_pkg::*;
#(
  parameter bit SHADOW_EN  = 1'b1,
  parameter int CPU_ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [CPU_ADDR_W-1:0]   req_addr,
  input  logic [1:0]              req_size,
  input  logic                    req_write,
  input  logic                    req_super,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic                    rsp_berr,
  output logic                    rsp_illegal,
  output logic [NSLOT-1:0]        slot_strobe,
  output logic                    slot_write,
  output logic [LANES-1:0]        lane_sel,
  output logic [LANES*ADDR_W-1:0] lane_addr,
  output logic [DATA_W-1:0]       bus_wdata,
  input  logic [DATA_W-1:0]       periph_rdata
);

  localparam logic [ADDR_W-1:0] ADDR_TOP = '1;

  logic [ADDR_W-1:0] a24;
  logic              unused_addr_hi;
  logic [CNT_W-1:0]  width_b;
  logic              size_bad;
  logic              priv_fault;
  logic              illegal;
  logic              fire;
  logic              go;
  logic              all_hole;
  logic [DATA_W-1:0] fill_data;

  logic [LANES-1:0][ADDR_W-1:0] lane_raw;
  logic [LANES-1:0][ADDR_W-1:0] lane_fold;
  lane_kind_e [LANES-1:0]       lane_kind;
  logic [LANES-1:0][SLOT_W-1:0] lane_slot;
  logic [LANES-1:0]             lane_act;

  assign a24            = req_addr[ADDR_W-1:0];
  assign unused_addr_hi = ^req_addr[CPU_ADDR_W-1:ADDR_W];

  always_comb begin
    size_bad = 1'b0;
    case (req_size)
      2'b00:   width_b = CNT_W'(1);
      2'b01:   width_b = CNT_W'(2);
      2'b10:   width_b = CNT_W'(4);
      default: begin
        width_b  = CNT_W'(LANES);
        size_bad = 1'b1;
      end
    endcase
  end

  assign priv_fault = (a24 < REGION_BASE) || !req_super;
  assign illegal    = size_bad ||
                      (a24 > (ADDR_TOP - ADDR_W'(width_b) + ADDR_W'(1)));

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign go        = fire && !priv_fault && !illegal;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_raw[k] = a24 + ADDR_W'(k);
    assign lane_act[k] = (CNT_W'(k) < width_b);

    io_lane_classify #(.SHADOW_EN(SHADOW_EN)) u_cls (
      .addr_i   (lane_raw[k]),
      .folded_o (lane_fold[k]),
      .kind_o   (lane_kind[k]),
      .slot_o   (lane_slot[k])
    );

    assign lane_addr[k*ADDR_W +: ADDR_W] = lane_fold[k];
  end

  io_select_gen u_sel (
    .go_i          (go),
    .act_i         (lane_act),
    .kind_i        (lane_kind),
    .slot_i        (lane_slot),
    .width_i       (width_b),
    .lane_sel_o    (lane_sel),
    .slot_strobe_o (slot_strobe),
    .all_hole_o    (all_hole)
  );

  io_read_fill u_fill (
    .act_i    (lane_act),
    .kind_i   (lane_kind),
    .periph_i (periph_rdata),
    .width_i  (width_b),
    .rdata_o  (fill_data)
  );

  assign slot_write = req_write && (|lane_sel);
  assign bus_wdata  = req_wdata << (8 * (LANES - int'(width_b)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_berr    <= 1'b0;
      rsp_illegal <= 1'b0;
    end else if (fire) begin
      rsp_valid   <= 1'b1;
      rsp_berr    <= priv_fault || (!illegal && all_hole);
      rsp_illegal <= !priv_fault && illegal;
      rsp_rdata   <= (go && !req_write && !all_hole) ? fill_data : '0;
    end else if (rsp_ready) begin
      rsp_valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/io_space_decoder_chk.sv
module io_space_decoder_chk
  import io_dec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_super,
  input logic [1:0]        req_size,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_berr,
  input logic              rsp_illegal,
  input logic [NSLOT-1:0]  slot_strobe,
  input logic [LANES-1:0]  lane_sel
);

  p_user_no_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_super) |-> (lane_sel == '0) && (slot_strobe == '0));

  p_user_berr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_super) |=> (rsp_valid && rsp_berr && !rsp_illegal));

  p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_berr && rsp_illegal));

  p_mapped_no_berr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_sel) |=> (rsp_valid && !rsp_berr));

  p_sel_on_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_sel) |-> (req_valid && req_ready));

  p_byte_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_size == 2'b00) |-> ($onehot0(slot_strobe) && ($countones(lane_sel) <= 1)));

  p_stall_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_rdata) && $stable(rsp_berr) && $stable(rsp_illegal)));

endmodule

bind io_space_decoder io_space_decoder_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_super   (req_super),
  .req_size    (req_size),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_rdata   (rsp_rdata),
  .rsp_berr    (rsp_berr),
  .rsp_illegal (rsp_illegal),
  .slot_strobe (slot_strobe),
  .lane_sel    (lane_sel)
);

// File: tb/io_space_decoder_test.sv
module io_space_decoder_test;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic        req_write;
  logic        req_super;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [31:0] rsp_rdata;
  logic        rsp_berr;
  logic        rsp_illegal;
  logic [4:0]  slot_strobe;
  logic        slot_write;
  logic [3:0]  lane_sel;
  logic [95:0] lane_addr;
  logic [31:0] bus_wdata;
  logic [31:0] periph_rdata;

  int total  = 0;
  int failed = 0;
  bit done   = 0;

  io_space_decoder uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_super(req_super),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_berr(rsp_berr), .rsp_illegal(rsp_illegal),
    .slot_strobe(slot_strobe), .slot_write(slot_write), .lane_sel(lane_sel),
    .lane_addr(lane_addr), .bus_wdata(bus_wdata), .periph_rdata(periph_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  size;
    logic        wr;
    logic        sup;
    logic        berr;
    logic        ill;
    logic [31:0] rdata;
    logic [4:0]  strobe;
  } vec_t;

  localparam int NV = 26;
  // periph_rdata is A1B2C3D4: lane0 A1, lane1 B2, lane2 C3, lane3 D4
  localparam vec_t VECS [NV] = '{
    '{32'h00FF8001, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h000000A1, 5'b00001}, // R11 R5 byte register
    '{32'h00FF8000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h00000000, 5'b00000}, // R4 lone hole
    '{32'h00FF8000, 2'd0+2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000FFB2, 5'b00001}, // R4 R5 hole+mapped
    '{32'h00FF8200, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000A1B2, 5'b00010}, // R8 word register
    '{32'h00FF8204, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFFFFFF, 5'b00000}, // R5 void-FF
    '{32'h00FF8208, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00000000, 5'b00000}, // R5 void-00
    '{32'h00FF8206, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFF0000, 5'b00000}, // R5 mixed voids
    '{32'h00FF8001, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h00000000, 5'b00000}, // R2 user mode
    '{32'h00FF7FFF, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h00000000, 5'b00000}, // R2 below region
    '{32'h12FF8001, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h000000A1, 5'b00001}, // R1 high bits ignored
    '{32'h00FFFA00, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 32'hA1B2C3D4, 5'b10000}, // R11 long register
    '{32'h00FFFFFD, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 32'h00000000, 5'b00000}, // R3 long past end
    '{32'h00FFFFFF, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 32'h00000000, 5'b00000}, // R3 word past end
    '{32'h00FFFFFE, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h00000000, 5'b00000}, // R3 R4 last legal word
    '{32'h00FF8001, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 32'h00000000, 5'b00000}, // R3 size code 11
    '{32'h00FF8804, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h000000A1, 5'b00100}, // R7 low shadow
    '{32'h00FF88FE, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h000000A1, 5'b01000}, // R7 high shadow
    '{32'h00FF88FD, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h00000000, 5'b00000}, // R7 shadow of a hole
    '{32'h00FF8800, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 32'hA1FFC3FF, 5'b01100}, // R8 two byte registers
    '{32'h00FF8804, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 32'hA1FFC3FF, 5'b01100}, // R7 R8 shadow long
    '{32'h00FF8204, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 32'h00000000, 5'b00000}, // R6 void write
    '{32'h00FF8000, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h00000000, 5'b00000}, // R4 R6 hole write
    '{32'h00FF8200, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h00000000, 5'b00010}, // R6 register write
    '{32'h00FF8001, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h00000000, 5'b00001}, // R4 write mapped+hole
    '{32'h00FFFFFC, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 32'h00000000, 5'b00000}, // R3 R4 last legal long
    '{32'h00FF7FFF, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h00000000, 5'b00000}  // R2 base below region
  };

  task automatic drive(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                       input logic sup, input logic [31:0] wd);
    req_addr  = a;
    req_size  = sz;
    req_write = wr;
    req_super = sup;
    req_wdata = wd;
    req_valid = 1'b1;
  endtask

  initial begin
    rst_n        = 1'b0;
    req_valid    = 1'b0;
    req_addr     = '0;
    req_size     = '0;
    req_write    = 1'b0;
    req_super    = 1'b1;
    req_wdata    = '0;
    rsp_ready    = 1'b1;
    periph_rdata = 32'hA1B2C3D4;

    repeat (3) @(negedge clk);
    check("R10 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    check("R10 req_ready in reset", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 rsp_valid after reset", 32'(rsp_valid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].addr, VECS[i].size, VECS[i].wr, VECS[i].sup, 32'h0);
      #2;
      check($sformatf("R8 strobe vec %0d", i), 32'(slot_strobe), 32'(VECS[i].strobe));
      check($sformatf("R6 write flag vec %0d", i), 32'(slot_write),
            32'(VECS[i].wr && (VECS[i].strobe != 0)));
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      check($sformatf("R9 rsp_valid vec %0d", i), 32'(rsp_valid), 32'd1);
      check($sformatf("R4 berr vec %0d", i), 32'(rsp_berr), 32'(VECS[i].berr));
      check($sformatf("R3 illegal vec %0d", i), 32'(rsp_illegal), 32'(VECS[i].ill));
      check($sformatf("R5 rdata vec %0d", i), rsp_rdata, VECS[i].rdata);
    end

    // R7: folded address shown on lane 0
    @(negedge clk);
    drive(32'h00FF88FE, 2'd0, 1'b0, 1'b1, 32'h0);
    #2;
    check("R7 lane0 folded address", 32'(lane_addr[23:0]), 32'h00FF8802);
    @(negedge clk);
    req_valid = 1'b0;

    // R6: word write selects lanes 0 and 1, data lane-indexed
    @(negedge clk);
    drive(32'h00FF8200, 2'd1, 1'b1, 1'b1, 32'h00001234);
    #2;
    check("R6 lane_sel word write", 32'(lane_sel), 32'h3);
    check("R6 bus_wdata lanes", bus_wdata, 32'h12340000);
    @(negedge clk);
    req_valid = 1'b0;

    // R2: user-mode write raises no select
    @(negedge clk);
    drive(32'h00FF8200, 2'd1, 1'b1, 1'b0, 32'h00001234);
    #2;
    check("R2 user write lane_sel", 32'(lane_sel), 32'h0);
    @(negedge clk);
    req_valid = 1'b0;

    // R9: back-pressure holds the response and blocks requests
    @(negedge clk);
    rsp_ready = 1'b0;
    drive(32'h00FFFA00, 2'd2, 1'b0, 1'b1, 32'h0);
    @(negedge clk);
    drive(32'h00FF8001, 2'd0, 1'b0, 1'b1, 32'h0);
    #2;
    check("R9 ready low under stall", 32'(req_ready), 32'd0);
    check("R9 no strobe while stalled", 32'(slot_strobe), 32'd0);
    repeat (2) @(negedge clk);
    #2;
    check("R9 held rdata", rsp_rdata, 32'hA1B2C3D4);
    check("R9 held valid", 32'(rsp_valid), 32'd1);
    rsp_ready = 1'b1;
    #1;
    check("R9 ready on drain", 32'(req_ready), 32'd1);
    check("R9 strobe on drain accept", 32'(slot_strobe), 32'h01);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check("R9 next response data", rsp_rdata, 32'h000000A1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

endmodule